// File: doc/BRIEF.md
# Shared-Memory Multi-Queue FIFO

This block places up to sixteen independent first-in first-out queues in one word memory, behind a single write port and a single read port that share a clock. The memory is split into equal blocks. At elaboration time each queue is given a whole number of blocks, and a queue may be given none. Queues occupy contiguous block ranges in queue-index order. Each queue keeps its own pointers and occupancy.

The write port names a target queue on a select input. A word offered with the write enable is stored in that queue unless the queue is full. The read port names a source queue and presents words in first-word-fall-through style. The head word of the selected queue appears on the output register with a valid flag and no request. Asserting the read enable while the flag is high consumes that word. The write side reports full and almost-full for its selected queue, and the read side reports almost-empty for its selected queue. When the read side moves to an empty queue, the valid flag drops but the last word stays on the output. Reads and writes may target the same queue or different queues in the same cycle.

Top module: `mq_fifo`

## Requirements
- R1: A queue given N blocks holds N*BLK_WORDS words. Full is high exactly when the selected write queue holds that many words. A queue given zero blocks always reports full and almost-full, and never produces a valid output word.
- R2: A write enable while the selected write queue is full is ignored: the offered word never appears at the read port.
- R3: When the selected read queue is not empty, its head word is driven on rd_data with out_valid high and no read enable. A read enable while out_valid is high consumes that word. If at least one more word remains, the following word is shown in the next cycle.
- R4: A read enable while out_valid is low has no effect, and no word of any queue is consumed.
- R5: When the read side selects an empty queue, out_valid goes low and rd_data keeps the last word shown. Words not consumed stay in their queue and reappear when it is selected again.
- R6: A change on wr_qsel or rd_qsel takes effect one clock later. A word newly shown after a read-select change is valid two clocks after the change is presented.
- R7: almost_full is high when the selected write queue holds at least depth minus AF_GAP words, and it is always high when full is high.
- R8: almost_empty is high when the selected read queue holds at most AE_LEVEL words. The word currently shown on rd_data counts as held.
- R9: With a read and a write on the same queue every cycle, words leave in the order they were written, one per cycle, including across the wrap of that queue's block range.
- R10: A read from one queue and a write into another in the same cycle proceed independently, and each queue keeps its own order.
- R11: After reset both selects point to queue 0, every queue is empty, out_valid is low and rd_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_qsel | input | QW | Target queue for writes |
| wr_en | input | 1 | Store wr_data into the selected write queue |
| wr_data | input | DW | Word to store |
| full | output | 1 | Selected write queue has no free word |
| almost_full | output | 1 | Selected write queue is within AF_GAP words of full |
| rd_qsel | input | QW | Source queue for reads |
| rd_en | input | 1 | Consume the word shown on rd_data |
| rd_data | output | DW | Output register |
| out_valid | output | 1 | rd_data holds the head of a queue |
| almost_empty | output | 1 | Selected read queue holds at most AE_LEVEL words |

## Verification
The bench uses the default parameters: 16-bit words, four queues, four-word blocks and eight blocks of memory. Queues 0 to 3 are given 2, 3, 0 and 2 blocks, so their depths are 8, 12, 0 and 8 words. AF_GAP is 2 and AE_LEVEL is 1. With these values queue 0 can be filled to full and drained in a few dozen cycles. The empty queue 2 exercises the zero-block case. Twenty-two words through queue 1 force its pointers across the end of a range that does not start at address zero.

// File: rtl/mq_pkg.sv
package mq_pkg;

   localparam int unsigned MAX_Q     = 16;
   localparam int unsigned BLK_FIELD = 8;

   // Block allocation map: field q (BLK_FIELD bits, queue 0 in the low field)
   typedef logic [MAX_Q*BLK_FIELD-1:0] blk_map_t;

   function automatic int unsigned blocks_of(blk_map_t m, int unsigned q);
      return 32'(m[q*BLK_FIELD +: BLK_FIELD]);
   endfunction

   // First block index of queue q: blocks of all lower-numbered queues
   function automatic int unsigned first_block(blk_map_t m, int unsigned q);
      int unsigned s;
      s = 0;
      for (int unsigned i = 0; i < q; i++) s += blocks_of(m, i);
      return s;
   endfunction

endpackage

// File: rtl/mq_store.sv
module mq_store #(
   parameter int unsigned DW    = 16,
   parameter int unsigned WORDS = 32,
   parameter int unsigned AW    = 5
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   logic [DW-1:0] cells [WORDS];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/mq_queue_ctl.sv
module mq_queue_ctl #(
   parameter int unsigned AW       = 5,
   parameter int unsigned CW       = 6,
   parameter int unsigned BASE     = 0,
   parameter int unsigned DEPTH    = 8,
   parameter int unsigned AF_GAP   = 2,
   parameter int unsigned AE_LEVEL = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   output logic [AW-1:0] wptr,
   output logic [AW-1:0] rptr,
   output logic [AW-1:0] rptr_inc,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          afull,
   output logic          aempty
);

   generate
      if (DEPTH == 0) begin : g_none
         logic unused_in;
         assign unused_in = ^{clk, rst_n, push, pop};
         assign wptr     = '0;
         assign rptr     = '0;
         assign rptr_inc = '0;
         assign count    = '0;
         assign full     = 1'b1;
         assign afull    = 1'b1;
         assign aempty   = 1'b1;
      end else begin : g_live
         localparam logic [AW-1:0] LO      = AW'(BASE);
         localparam logic [AW-1:0] HI      = AW'(BASE + DEPTH - 1);
         localparam logic [CW-1:0] DEP_C   = CW'(DEPTH);
         localparam logic [CW-1:0] AF_MARK = (DEPTH > AF_GAP) ? CW'(DEPTH - AF_GAP) : '0;
         localparam logic [CW-1:0] AE_C    = CW'(AE_LEVEL);

         logic [AW-1:0] wptr_inc;

         assign wptr_inc = (wptr == HI) ? LO : wptr + AW'(1);
         assign rptr_inc = (rptr == HI) ? LO : rptr + AW'(1);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wptr  <= LO;
               rptr  <= LO;
               count <= '0;
            end else begin
               if (push) wptr <= wptr_inc;
               if (pop)  rptr <= rptr_inc;
               case ({push, pop})
                  2'b10:   count <= count + CW'(1);
                  2'b01:   count <= count - CW'(1);
                  default: count <= count;
               endcase
            end
         end

         assign full   = (count == DEP_C);
         assign afull  = (count >= AF_MARK);
         assign aempty = (count <= AE_C);
      end
   endgenerate

endmodule

// File: rtl/mq_fifo.sv
module mq_fifo
   import mq_pkg::*;
#(
   parameter int unsigned DW         = 16,
   parameter int unsigned NUM_Q      = 4,
   parameter int unsigned BLK_WORDS  = 4,
   parameter int unsigned TOTAL_BLKS = 8,
   parameter blk_map_t    Q_BLOCKS   = 128'h0200_0302,
   parameter int unsigned AF_GAP     = 2,
   parameter int unsigned AE_LEVEL   = 1,
   localparam int unsigned QW        = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [QW-1:0] wr_qsel,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   output logic          full,
   output logic          almost_full,
   input  logic [QW-1:0] rd_qsel,
   input  logic          rd_en,
   output logic [DW-1:0] rd_data,
   output logic          out_valid,
   output logic          almost_empty
);

   localparam int unsigned MEM_WORDS = TOTAL_BLKS * BLK_WORDS;
   localparam int unsigned AW        = $clog2(MEM_WORDS);
   localparam int unsigned CW        = $clog2(MEM_WORDS + 1);
   localparam int unsigned QN        = 1 << QW;

   // Elaboration-time parameter checks
   generate
      if (NUM_Q < 1 || NUM_Q > MAX_Q) begin : g_bad_qcount
         $error("NUM_Q must lie between 1 and %0d", MAX_Q);
      end
      if (MEM_WORDS < 2) begin : g_bad_mem
         $error("memory must hold at least two words");
      end
      if (first_block(Q_BLOCKS, NUM_Q) > TOTAL_BLKS) begin : g_bad_alloc
         $error("queues are given more blocks than TOTAL_BLKS");
      end
      if (AE_LEVEL >= MEM_WORDS) begin : g_bad_ae
         $error("AE_LEVEL must be below the memory size");
      end
   endgenerate

   // Registered selects and output stage
   logic [QW-1:0] wsel_q, rsel_q, src_q;
   logic [DW-1:0] dout_q;
   logic          ov_q;

   // Per-queue state views
   logic [AW-1:0] wp  [QN];
   logic [AW-1:0] rp  [QN];
   logic [AW-1:0] rpi [QN];
   logic [CW-1:0] cnt [QN];
   logic [QN-1:0] q_full, q_afull, q_aempty, push_v, pop_v;

   logic          push_ok, pop_ok, same_q, avail;
   logic [AW-1:0] head_addr;
   logic [DW-1:0] mem_rd;

   generate
      for (genvar q = 0; q < QN; q++) begin : g_q
         localparam int unsigned NB = (q < NUM_Q) ? blocks_of(Q_BLOCKS, q) : 0;
         mq_queue_ctl #(
            .AW       (AW),
            .CW       (CW),
            .BASE     (first_block(Q_BLOCKS, q) * BLK_WORDS),
            .DEPTH    (NB * BLK_WORDS),
            .AF_GAP   (AF_GAP),
            .AE_LEVEL (AE_LEVEL)
         ) u_ctl (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (push_v[q]),
            .pop      (pop_v[q]),
            .wptr     (wp[q]),
            .rptr     (rp[q]),
            .rptr_inc (rpi[q]),
            .count    (cnt[q]),
            .full     (q_full[q]),
            .afull    (q_afull[q]),
            .aempty   (q_aempty[q])
         );
      end
   endgenerate

   // Write side
   assign push_ok = wr_en & ~q_full[wsel_q];
   assign push_v  = push_ok ? (QN'(1) << wsel_q) : '0;

   // Read side: the shown word belongs to src_q and is consumed on request
   assign pop_ok    = rd_en & ov_q;
   assign pop_v     = pop_ok ? (QN'(1) << src_q) : '0;
   assign same_q    = pop_ok && (src_q == rsel_q);
   assign head_addr = same_q ? rpi[rsel_q] : rp[rsel_q];
   assign avail     = same_q ? (cnt[rsel_q] > CW'(1)) : (cnt[rsel_q] != '0);

   mq_store #(
      .DW    (DW),
      .WORDS (MEM_WORDS),
      .AW    (AW)
   ) u_store (
      .clk   (clk),
      .we    (push_ok),
      .waddr (wp[wsel_q]),
      .wdata (wr_data),
      .raddr (head_addr),
      .rdata (mem_rd)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wsel_q <= '0;
         rsel_q <= '0;
         src_q  <= '0;
         dout_q <= '0;
         ov_q   <= 1'b0;
      end else begin
         wsel_q <= wr_qsel;
         rsel_q <= rd_qsel;
         if (avail) begin
            dout_q <= mem_rd;
            src_q  <= rsel_q;
            ov_q   <= 1'b1;
         end else begin
            ov_q   <= 1'b0;
         end
      end
   end

   assign full         = q_full[wsel_q];
   assign almost_full  = q_afull[wsel_q];
   assign almost_empty = q_aempty[rsel_q];
   assign rd_data      = dout_q;
   assign out_valid    = ov_q;

endmodule

// File: rtl/mq_fifo_chk.sv
module mq_fifo_chk
   import mq_pkg::*;
#(
   parameter int unsigned DW       = 16,
   parameter int unsigned QW       = 2,
   parameter int unsigned NUM_Q    = 4,
   parameter blk_map_t    Q_BLOCKS = '0
) (
   input logic          clk,
   input logic          rst_n,
   input logic [QW-1:0] wr_qsel,
   input logic          full,
   input logic          almost_full,
   input logic [QW-1:0] rd_qsel,
   input logic          rd_en,
   input logic [DW-1:0] rd_data,
   input logic          out_valid
);

   logic [1:0] age;

   always_ff @(posedge clk) begin
      if (!rst_n)          age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   function automatic logic no_blocks(logic [QW-1:0] s);
      return (32'(s) >= NUM_Q) || (blocks_of(Q_BLOCKS, 32'(s)) == 0);
   endfunction

   // R1: a queue without blocks reports full and almost-full once selected
   a_r1_zero_block_full: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 2'd0 && no_blocks($past(wr_qsel))) |-> (full && almost_full));

   // R2: without a consumer and with a steady select, a full queue stays full
   a_r2_full_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 2'd0 && full && wr_qsel == $past(wr_qsel) && !(rd_en && out_valid))
      |=> full);

   // R4: a shown word stays shown until consumed while the read select is steady
   a_r4_valid_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && out_valid && !rd_en &&
       rd_qsel == $past(rd_qsel) && $past(rd_qsel) == $past(rd_qsel, 2))
      |=> (out_valid && $stable(rd_data)));

   // R5: the output word is kept when valid drops
   a_r5_hold_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 2'd0 && $fell(out_valid)) |-> $stable(rd_data));

   // R7: full always comes with almost-full
   a_r7_full_has_af: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> almost_full);

endmodule

bind mq_fifo mq_fifo_chk #(
   .DW       (DW),
   .QW       (QW),
   .NUM_Q    (NUM_Q),
   .Q_BLOCKS (Q_BLOCKS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_qsel     (wr_qsel),
   .full        (full),
   .almost_full (almost_full),
   .rd_qsel     (rd_qsel),
   .rd_en       (rd_en),
   .rd_data     (rd_data),
   .out_valid   (out_valid)
);

// File: tb/mq_fifo_test.sv
`timescale 1ns/1ps
module mq_fifo_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  wr_qsel, rd_qsel;
   logic        wr_en, rd_en;
   logic [15:0] wr_data;
   logic        full, almost_full, out_valid, almost_empty;
   logic [15:0] rd_data;

   int checks = 0;
   int fails  = 0;
   logic [15:0] exp_q [$];

   always #2.5 clk = ~clk;

   mq_fifo uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_qsel      (wr_qsel),
      .wr_en        (wr_en),
      .wr_data      (wr_data),
      .full         (full),
      .almost_full  (almost_full),
      .rd_qsel      (rd_qsel),
      .rd_en        (rd_en),
      .rd_data      (rd_data),
      .out_valid    (out_valid),
      .almost_empty (almost_empty)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic see(input logic v, input logic [15:0] d, input string req);
      chk(out_valid === v, {req, " out_valid"}, 32'(out_valid), 32'(v));
      chk(rd_data === d, {req, " rd_data"}, 32'(rd_data), 32'(d));
   endtask

   // R11: state right after reset
   task automatic t_reset();
      rst_n = 1'b0; wr_qsel = '0; rd_qsel = '0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
      repeat (3) tick();
      rst_n = 1'b1;
      see(1'b0, 16'h0, "R11 reset");
      chk(full === 1'b0, "R11 full", 32'(full), 0);
      chk(almost_full === 1'b0, "R11 almost_full", 32'(almost_full), 0);
      chk(almost_empty === 1'b1, "R11 almost_empty", 32'(almost_empty), 1);
   endtask

   // R1 R7 R8 R2: fill queue 0 (depth 8) and try one more word
   task automatic t_fill_q0();
      for (int i = 0; i < 8; i++) begin
         wr_en = 1'b1; wr_data = 16'h0100 + 16'(i);
         tick();
         chk(full === (i == 7), "R1 full at depth", 32'(full), 32'(i == 7));
         chk(almost_full === (i >= 5), "R7 almost_full level", 32'(almost_full), 32'(i >= 5));
         chk(almost_empty === (i == 0), "R8 almost_empty level", 32'(almost_empty), 32'(i == 0));
      end
      wr_data = 16'hDEAD;
      tick();
      wr_en = 1'b0;
      chk(full === 1'b1, "R2 full after refused write", 32'(full), 1);
   endtask

   // R3 R2 R5: drain queue 0 in order, refused word must not show up
   task automatic t_drain_q0();
      see(1'b1, 16'h0100, "R3 fall-through");
      chk(almost_empty === 1'b0, "R8 almost_empty high count", 32'(almost_empty), 0);
      rd_en = 1'b1;
      for (int i = 0; i < 8; i++) begin
         see(1'b1, 16'h0100 + 16'(i), "R3 stream");
         tick();
      end
      see(1'b0, 16'h0107, "R2 no refused word / R5 hold");
      rd_en = 1'b0;
      chk(full === 1'b0, "R1 full clears", 32'(full), 0);
   endtask

   // R1: queue 2 has no blocks
   task automatic t_zero_q();
      wr_qsel = 2'd2;
      tick();
      chk(full === 1'b1, "R1 zero-block full", 32'(full), 1);
      chk(almost_full === 1'b1, "R1 zero-block almost_full", 32'(almost_full), 1);
      wr_en = 1'b1; wr_data = 16'hBAD0;
      tick();
      wr_en = 1'b0;
      rd_qsel = 2'd2;
      tick(); tick();
      chk(out_valid === 1'b0, "R1 zero-block never valid", 32'(out_valid), 0);
      chk(almost_empty === 1'b1, "R8 zero-block almost_empty", 32'(almost_empty), 1);
   endtask

   // R6 R5 R4: select latency, switching to empty, ignored read
   task automatic t_switch();
      wr_qsel = 2'd1; tick();
      wr_en = 1'b1; wr_data = 16'h0200; tick();
      wr_data = 16'h0201; tick();
      wr_en = 1'b0; wr_qsel = 2'd3; tick();
      wr_en = 1'b1; wr_data = 16'h0300; tick();
      wr_en = 1'b0;
      rd_qsel = 2'd1;
      tick();
      chk(out_valid === 1'b0, "R6 read select latency", 32'(out_valid), 0);
      tick();
      see(1'b1, 16'h0200, "R6 new queue shown");
      rd_qsel = 2'd0;
      tick();
      see(1'b1, 16'h0200, "R6 old word one more cycle");
      tick();
      see(1'b0, 16'h0200, "R5 empty queue keeps word");
      rd_en = 1'b1; tick(); rd_en = 1'b0;
      rd_qsel = 2'd1;
      tick(); tick();
      see(1'b1, 16'h0200, "R4 read while invalid ignored");
      rd_qsel = 2'd3;
      tick(); tick();
      see(1'b1, 16'h0300, "R5 other queue shown");
      rd_en = 1'b1; tick(); rd_en = 1'b0;
      see(1'b0, 16'h0300, "R3 last word consumed");
   endtask

   // R9: same-queue read and write each cycle, wrapping queue 1
   task automatic t_same_q();
      exp_q = {16'h0200, 16'h0201};
      rd_qsel = 2'd1; wr_qsel = 2'd1;
      tick(); tick();
      for (int j = 0; j < 20; j++) begin
         see(1'b1, exp_q[0], "R9 concurrent order");
         rd_en = 1'b1; wr_en = 1'b1; wr_data = 16'h0400 + 16'(j);
         tick();
         void'(exp_q.pop_front());
         exp_q.push_back(16'h0400 + 16'(j));
      end
      wr_en = 1'b0;
      while (exp_q.size() > 0) begin
         see(1'b1, exp_q[0], "R9 drain order");
         tick();
         void'(exp_q.pop_front());
      end
      rd_en = 1'b0;
      see(1'b0, 16'h0413, "R9 empty after drain");
   endtask

   // R10: read queue 3 while writing queue 0
   task automatic t_cross();
      wr_qsel = 2'd3; tick();
      for (int j = 0; j < 3; j++) begin
         wr_en = 1'b1; wr_data = 16'h0500 + 16'(j); tick();
      end
      wr_en = 1'b0;
      rd_qsel = 2'd3; wr_qsel = 2'd0;
      tick(); tick();
      for (int j = 0; j < 3; j++) begin
         see(1'b1, 16'h0500 + 16'(j), "R10 read side order");
         rd_en = 1'b1; wr_en = 1'b1; wr_data = 16'h0600 + 16'(j);
         tick();
      end
      rd_en = 1'b0; wr_en = 1'b0;
      see(1'b0, 16'h0502, "R10 read queue emptied");
      rd_qsel = 2'd0;
      tick(); tick();
      rd_en = 1'b1;
      for (int j = 0; j < 3; j++) begin
         see(1'b1, 16'h0600 + 16'(j), "R10 write side order");
         tick();
      end
      rd_en = 1'b0;
      chk(out_valid === 1'b0, "R10 write queue emptied", 32'(out_valid), 0);
   endtask

   initial begin
      t_reset();
      t_fill_q0();
      t_drain_q0();
      t_zero_q();
      t_switch();
      t_same_q();
      t_cross();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #1000000;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule